// File: doc/BRIEF.md
# RISC Subset Decode and Execute Stage

This block is a single-cycle decode and execute stage for a small subset of a classic 32-bit RISC instruction set. Each cycle it takes one 32-bit instruction word and that instruction's program counter. It splits the word into register, immediate or jump form and reads two operands from an internal 32 by 32-bit register file. It then computes an arithmetic, logical or compare result, or an effective address, and decides the program counter for the next instruction. The result is written back into the register file at the next rising clock edge.

Loads and stores are not executed here. The block gives an address, byte-lane enables, store data and read/write strobes to a separate memory unit. That unit returns the addressed aligned word combinationally on `load_data_i` in the same cycle, and the selected value is written back. The writeback index, enable and value also appear as outputs, so a surrounding core or a bench can follow register updates.

Top module: `rsx_core`

## Requirements
- R1: After a synchronous active-high reset, every register reads as zero.
- R2: Opcode 0 with funct 32 writes rs+rt to rd, and with funct 34 writes rs-rt to rd. Both wrap modulo 2^32.
- R3: Opcode 0 with funct 42 (slt), and opcode 10 (slti, immediate sign-extended from bit 15), write 1 to the destination when the first operand is less than the second as two's-complement numbers, and 0 otherwise.
- R4: Opcode 8 (addi) writes rs plus the immediate sign-extended from bit 15 into rt. Opcode 13 (ori) writes rs OR the zero-extended immediate into rt.
- R5: Opcode 15 (lui) writes the 16-bit immediate into rt bits 31:16 and clears bits 15:0.
- R6: Register 0 always reads as zero. A write aimed at it is dropped and `wb_en_o` stays low.
- R7: Opcodes 35 (lw) and 32 (lb) raise `mem_rd_o` with address rs plus the sign-extended offset. lw writes `load_data_i` to rt. lb takes the byte big-endian (address bits 1:0 = 0 selects bits 31:24, 3 selects bits 7:0), sign-extends it and writes it to rt. `mem_be_o` is 4'b1111 for lw and 4'b1000 shifted right by the address bits 1:0 for lb.
- R8: Opcodes 43 (sw) and 40 (sb) raise `mem_wr_o`, present rt on `mem_wdata_o` and write no register. sw drives `mem_be_o` to 4'b1111. sb repeats rt bits 7:0 in all four byte lanes and enables exactly one lane, 4'b1000 shifted right by address bits 1:0.
- R9: Opcode 4 (beq) and opcode 5 (bne) are taken when rs equals / differs from rt. The taken target is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise the next PC is PC+4.
- R10: Opcode 2 (j) and opcode 3 (jal) go to {(PC+4)[31:28], target[25:0], 2'b00}. jal also writes PC+4 into register 31.
- R11: Opcode 0 with funct 8 (jr) sets the next PC to the value of rs.
- R12: Any other opcode, or any other funct under opcode 0, raises `illegal_o`. It writes no register, raises no memory strobe and gives a next PC of PC+4.
- R13: Every instruction that is not a taken branch, a jump or jr gives a next PC of PC+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writeback happens on the rising edge |
| rst | input | 1 | Synchronous active-high reset, clears the register file |
| instr_i | input | 32 | Instruction word to execute this cycle |
| pc_i | input | 32 | Address of the instruction |
| load_data_i | input | 32 | Aligned word returned by the memory unit for a load |
| next_pc_o | output | 32 | Address of the following instruction |
| illegal_o | output | 1 | Unrecognised opcode or funct |
| mem_addr_o | output | 32 | Effective byte address for a load or store |
| mem_wdata_o | output | 32 | Store data, byte-replicated for sb |
| mem_rd_o | output | 1 | Load request |
| mem_wr_o | output | 1 | Store request |
| mem_be_o | output | 4 | Byte-lane enables, bit 3 is the lowest address |
| wb_en_o | output | 1 | A register is written at the next edge |
| wb_idx_o | output | 5 | Destination register index |
| wb_data_o | output | 32 | Value being written back |

## Verification
The checker tests on every cycle the rules that tie outputs together. Register 0 is never the target of an enabled write. An illegal word stays silent and falls through to PC+4. Stores never write back, and sb enables one lane only. jal links PC+4 into register 31. lui clears the low half. Sequential PCs stay word-aligned. Arithmetic values, signed compares across the sign boundary, byte selection for loads, branch targets with negative displacements and the contents of the register file after reset and after writes can only be shown by the bench. The bench sweeps operand pairs and immediates and reads registers back through the store data path.

// File: rtl/rsx_pkg.sv
package rsx_pkg;

    localparam int XLEN    = 32;
    localparam int NREG    = 32;
    localparam int RIDX    = $clog2(NREG);
    localparam int IMMW    = 16;
    localparam int TGTW    = 26;
    localparam int NLANE   = XLEN / 8;
    localparam int LANEIDX = $clog2(NLANE);
    localparam logic [RIDX-1:0] LINK_REG = RIDX'(NREG - 1);

    localparam logic [5:0] OP_RTYPE = 6'd0;
    localparam logic [5:0] OP_J     = 6'd2;
    localparam logic [5:0] OP_JAL   = 6'd3;
    localparam logic [5:0] OP_BEQ   = 6'd4;
    localparam logic [5:0] OP_BNE   = 6'd5;
    localparam logic [5:0] OP_ADDI  = 6'd8;
    localparam logic [5:0] OP_SLTI  = 6'd10;
    localparam logic [5:0] OP_ORI   = 6'd13;
    localparam logic [5:0] OP_LUI   = 6'd15;
    localparam logic [5:0] OP_LB    = 6'd32;
    localparam logic [5:0] OP_LW    = 6'd35;
    localparam logic [5:0] OP_SB    = 6'd40;
    localparam logic [5:0] OP_SW    = 6'd43;

    localparam logic [5:0] FN_JR  = 6'd8;
    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_OR, ALU_LUI, ALU_SLT} alu_op_e;
    typedef enum logic [1:0] {DST_RD, DST_RT, DST_LINK} dst_e;
    typedef enum logic [1:0] {WB_ALU, WB_LOAD, WB_LINK} wbsrc_e;
    typedef enum logic [1:0] {PC_SEQ, PC_BR, PC_JMP, PC_REG} pcsel_e;

    typedef struct packed {
        logic [5:0]      op;
        logic [RIDX-1:0] rs;
        logic [RIDX-1:0] rt;
        logic [RIDX-1:0] rd;
        logic [4:0]      shamt;
        logic [5:0]      funct;
    } word_t;

    typedef struct packed {
        alu_op_e alu_op;
        logic    use_imm;
        logic    imm_zext;
        logic    wr_en;
        dst_e    dst;
        wbsrc_e  wb_src;
        logic    mem_rd;
        logic    mem_wr;
        logic    mem_byte;
        pcsel_e  pc_sel;
        logic    br_ne;
        logic    illegal;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMMW-1:0] v);
        return {{(XLEN-IMMW){v[IMMW-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] zext_imm(input logic [IMMW-1:0] v);
        return {{(XLEN-IMMW){1'b0}}, v};
    endfunction

    function automatic logic [7:0] lane_byte(input logic [XLEN-1:0] w,
                                             input logic [LANEIDX-1:0] sel);
        return w[(NLANE-1-int'(sel))*8 +: 8];
    endfunction

endpackage

// File: rtl/rsx_decode.sv
module rsx_decode
    import rsx_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);
    word_t w;
    assign w = word_t'(instr);

    always_comb begin
        ctrl.alu_op   = ALU_ADD;
        ctrl.use_imm  = 1'b0;
        ctrl.imm_zext = 1'b0;
        ctrl.wr_en    = 1'b0;
        ctrl.dst      = DST_RT;
        ctrl.wb_src   = WB_ALU;
        ctrl.mem_rd   = 1'b0;
        ctrl.mem_wr   = 1'b0;
        ctrl.mem_byte = 1'b0;
        ctrl.pc_sel   = PC_SEQ;
        ctrl.br_ne    = 1'b0;
        ctrl.illegal  = 1'b0;
        case (w.op)
            OP_RTYPE: begin
                ctrl.dst = DST_RD;
                case (w.funct)
                    FN_ADD: begin ctrl.alu_op = ALU_ADD; ctrl.wr_en = 1'b1; end
                    FN_SUB: begin ctrl.alu_op = ALU_SUB; ctrl.wr_en = 1'b1; end
                    FN_SLT: begin ctrl.alu_op = ALU_SLT; ctrl.wr_en = 1'b1; end
                    FN_JR:  ctrl.pc_sel = PC_REG;
                    default: ctrl.illegal = 1'b1;
                endcase
            end
            OP_ADDI: begin ctrl.use_imm = 1'b1; ctrl.wr_en = 1'b1; end
            OP_SLTI: begin
                ctrl.use_imm = 1'b1; ctrl.wr_en = 1'b1; ctrl.alu_op = ALU_SLT;
            end
            OP_ORI: begin
                ctrl.use_imm = 1'b1; ctrl.imm_zext = 1'b1;
                ctrl.wr_en = 1'b1; ctrl.alu_op = ALU_OR;
            end
            OP_LUI: begin
                ctrl.use_imm = 1'b1; ctrl.wr_en = 1'b1; ctrl.alu_op = ALU_LUI;
            end
            OP_LW, OP_LB: begin
                ctrl.use_imm = 1'b1; ctrl.wr_en = 1'b1; ctrl.wb_src = WB_LOAD;
                ctrl.mem_rd = 1'b1; ctrl.mem_byte = (w.op == OP_LB);
            end
            OP_SW, OP_SB: begin
                ctrl.use_imm = 1'b1; ctrl.mem_wr = 1'b1;
                ctrl.mem_byte = (w.op == OP_SB);
            end
            OP_BEQ: ctrl.pc_sel = PC_BR;
            OP_BNE: begin ctrl.pc_sel = PC_BR; ctrl.br_ne = 1'b1; end
            OP_J:   ctrl.pc_sel = PC_JMP;
            OP_JAL: begin
                ctrl.pc_sel = PC_JMP; ctrl.wr_en = 1'b1;
                ctrl.dst = DST_LINK; ctrl.wb_src = WB_LINK;
            end
            default: ctrl.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/rsx_regfile.sv
module rsx_regfile
    import rsx_pkg::*;
#(
    parameter int N = NREG,
    parameter int W = XLEN,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_idx,
    input  logic [AW-1:0] rb_idx,
    output logic [W-1:0]  ra_val,
    output logic [W-1:0]  rb_val,
    input  logic          we,
    input  logic [AW-1:0] w_idx,
    input  logic [W-1:0]  w_val
);
    logic [W-1:0] regs [1:N-1];

    for (genvar g = 1; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && w_idx == AW'(g))
                regs[g] <= w_val;
        end
    end

    assign ra_val = (ra_idx == '0) ? '0 : regs[ra_idx];
    assign rb_val = (rb_idx == '0) ? '0 : regs[rb_idx];
endmodule

// File: rtl/rsx_alu.sv
module rsx_alu
    import rsx_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            ALU_LUI: y = {b[IMMW-1:0], {(XLEN-IMMW){1'b0}}};
            ALU_SLT: y = XLEN'($signed(a) < $signed(b));
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/rsx_nextpc.sv
module rsx_nextpc
    import rsx_pkg::*;
(
    input  logic [XLEN-1:0] pc,
    input  pcsel_e          sel,
    input  logic            br_ne,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    input  logic [IMMW-1:0] imm,
    input  logic [TGTW-1:0] target,
    output logic [XLEN-1:0] pc_plus4,
    output logic [XLEN-1:0] next_pc
);
    logic            taken;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] j_tgt;

    assign pc_plus4 = pc + XLEN'(4);
    assign taken    = (rs_val == rt_val) ^ br_ne;
    assign br_tgt   = pc_plus4 + {sext_imm(imm)[XLEN-3:0], 2'b00};
    assign j_tgt    = {pc_plus4[XLEN-1:TGTW+2], target, 2'b00};

    always_comb begin
        case (sel)
            PC_BR:   next_pc = taken ? br_tgt : pc_plus4;
            PC_JMP:  next_pc = j_tgt;
            PC_REG:  next_pc = rs_val;
            default: next_pc = pc_plus4;
        endcase
    end
endmodule

// File: rtl/rsx_core.sv
module rsx_core
    import rsx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [XLEN-1:0]  instr_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [XLEN-1:0]  load_data_i,
    output logic [XLEN-1:0]  next_pc_o,
    output logic             illegal_o,
    output logic [XLEN-1:0]  mem_addr_o,
    output logic [XLEN-1:0]  mem_wdata_o,
    output logic             mem_rd_o,
    output logic             mem_wr_o,
    output logic [NLANE-1:0] mem_be_o,
    output logic             wb_en_o,
    output logic [RIDX-1:0]  wb_idx_o,
    output logic [XLEN-1:0]  wb_data_o
);
    word_t           w;
    ctrl_t           ctrl;
    logic [XLEN-1:0] rs_val, rt_val, opb, alu_y, pc_plus4, load_val;
    logic [IMMW-1:0] imm;
    logic [LANEIDX-1:0] lane;

    assign w    = word_t'(instr_i);
    assign imm  = instr_i[IMMW-1:0];

    rsx_decode u_dec (.instr(instr_i), .ctrl(ctrl));

    rsx_regfile #(.N(NREG), .W(XLEN)) u_rf (
        .clk(clk), .rst(rst),
        .ra_idx(w.rs), .rb_idx(w.rt),
        .ra_val(rs_val), .rb_val(rt_val),
        .we(wb_en_o), .w_idx(wb_idx_o), .w_val(wb_data_o)
    );

    assign opb = !ctrl.use_imm ? rt_val :
                 (ctrl.imm_zext ? zext_imm(imm) : sext_imm(imm));

    rsx_alu u_alu (.op(ctrl.alu_op), .a(rs_val), .b(opb), .y(alu_y));

    rsx_nextpc u_npc (
        .pc(pc_i), .sel(ctrl.pc_sel), .br_ne(ctrl.br_ne),
        .rs_val(rs_val), .rt_val(rt_val), .imm(imm),
        .target(instr_i[TGTW-1:0]),
        .pc_plus4(pc_plus4), .next_pc(next_pc_o)
    );

    assign lane        = alu_y[LANEIDX-1:0];
    assign mem_addr_o  = alu_y;
    assign mem_rd_o    = ctrl.mem_rd;
    assign mem_wr_o    = ctrl.mem_wr;
    assign mem_wdata_o = ctrl.mem_byte ? {NLANE{rt_val[7:0]}} : rt_val;
    assign mem_be_o    = !(ctrl.mem_rd || ctrl.mem_wr) ? '0 :
                         ctrl.mem_byte ? (NLANE'(1) << (NLANE - 1 - int'(lane))) : '1;

    assign load_val = ctrl.mem_byte
                    ? {{(XLEN-8){lane_byte(load_data_i, lane)[7]}}, lane_byte(load_data_i, lane)}
                    : load_data_i;

    always_comb begin
        case (ctrl.dst)
            DST_RD:   wb_idx_o = w.rd;
            DST_LINK: wb_idx_o = LINK_REG;
            default:  wb_idx_o = w.rt;
        endcase
        case (ctrl.wb_src)
            WB_LOAD: wb_data_o = load_val;
            WB_LINK: wb_data_o = pc_plus4;
            default: wb_data_o = alu_y;
        endcase
    end

    assign wb_en_o   = ctrl.wr_en && (wb_idx_o != '0);
    assign illegal_o = ctrl.illegal;
endmodule

// File: rtl/rsx_core_chk.sv
module rsx_core_chk
    import rsx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [XLEN-1:0]  instr_i,
    input logic [XLEN-1:0]  pc_i,
    input logic [XLEN-1:0]  next_pc_o,
    input logic             illegal_o,
    input logic             mem_rd_o,
    input logic             mem_wr_o,
    input logic [NLANE-1:0] mem_be_o,
    input logic             wb_en_o,
    input logic [RIDX-1:0]  wb_idx_o,
    input logic [XLEN-1:0]  wb_data_o
);
    logic [5:0] op;
    assign op = instr_i[31:26];

    AST_ZERO_REG_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        wb_en_o |-> wb_idx_o != '0); // R6

    AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!wb_en_o && !mem_rd_o && !mem_wr_o
                       && next_pc_o == pc_i + XLEN'(4))); // R12

    AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
        mem_wr_o |-> (!wb_en_o && !mem_rd_o)); // R8

    AST_SB_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_o && op == OP_SB) |-> $countones(mem_be_o) == 1); // R8

    AST_JAL_LINK: assert property (@(posedge clk) disable iff (rst)
        (op == OP_JAL) |-> (wb_en_o && wb_idx_o == LINK_REG
                            && wb_data_o == pc_i + XLEN'(4))); // R10

    AST_LUI_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LUI && wb_en_o) |-> wb_data_o[IMMW-1:0] == '0); // R5

    AST_SEQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (pc_i[1:0] == 2'b00 && !(op == OP_RTYPE && instr_i[5:0] == FN_JR))
        |-> next_pc_o[1:0] == 2'b00); // R13
endmodule

bind rsx_core rsx_core_chk u_chk (
    .clk(clk), .rst(rst), .instr_i(instr_i), .pc_i(pc_i),
    .next_pc_o(next_pc_o), .illegal_o(illegal_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_be_o(mem_be_o),
    .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o)
);

// File: tb/tb_rsx_core.sv
module tb_rsx_core;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr_i = '0, pc_i = '0, load_data_i = '0;
    logic [31:0] next_pc_o, mem_addr_o, mem_wdata_o, wb_data_o;
    logic        illegal_o, mem_rd_o, mem_wr_o, wb_en_o;
    logic [3:0]  mem_be_o;
    logic [4:0]  wb_idx_o;

    rsx_core dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    logic [31:0] c_npc, c_addr, c_wd, c_wbd;
    logic        c_ill, c_rd, c_wr, c_wen;
    logic [3:0]  c_be;
    logic [4:0]  c_widx;
    logic [31:0] mdl [32];

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] im);
        return {op, 5'(rs), 5'(rt), im};
    endfunction
    function automatic logic [31:0] sx(logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(logic [31:0] ins, logic [31:0] pc, logic [31:0] ld);
        instr_i = ins; pc_i = pc; load_data_i = ld;
        #1;
        c_npc = next_pc_o; c_ill = illegal_o; c_addr = mem_addr_o; c_wd = mem_wdata_o;
        c_rd = mem_rd_o; c_wr = mem_wr_o; c_be = mem_be_o; c_wen = wb_en_o;
        c_widx = wb_idx_o; c_wbd = wb_data_o;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] rd_reg_ins(int r);
        return enc_i(6'd43, 0, r, 16'h0);
    endfunction

    task automatic read_reg(int r, output logic [31:0] v);
        step(rd_reg_ins(r), 32'h100, 32'h0);
        v = c_wd;
    endtask

    task automatic set_reg(int r, logic [31:0] v);
        step(enc_i(6'd15, 0, r, v[31:16]), 32'h200, 32'h0);
        step(enc_i(6'd13, r, r, v[15:0]), 32'h204, 32'h0);
        if (r != 0) mdl[r] = v;
    endtask

    task automatic cmp_reg(string req, int r);
        logic [31:0] v;
        read_reg(r, v);
        chk(req, v, mdl[r]);
    endtask

    logic [31:0] vals [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                              32'h8000_0000, 32'h1234_5678, 32'hFFFF_8000, 32'h0000_7FFF};
    logic [15:0] imms [6] = '{16'h0, 16'h1, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: all registers clear after reset
        for (int r = 0; r < 32; r++) cmp_reg("R1", r);

        // R2, R3: register-register sweep over operand pairs
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                set_reg(1, vals[i]);
                set_reg(2, vals[j]);
                step(enc_r(1, 2, 3, 6'd32), 32'h300, 0);
                mdl[3] = vals[i] + vals[j];
                chk("R2 add wb", c_wbd, mdl[3]);
                step(enc_r(1, 2, 4, 6'd34), 32'h304, 0);
                mdl[4] = vals[i] - vals[j];
                step(enc_r(1, 2, 5, 6'd42), 32'h308, 0);
                mdl[5] = ($signed(vals[i]) < $signed(vals[j])) ? 32'd1 : 32'd0;
                cmp_reg("R2 sub", 4);
                cmp_reg("R3 slt", 5);
            end
        end

        // R3, R4: immediate sweep
        for (int i = 0; i < 8; i++) begin
            for (int k = 0; k < 6; k++) begin
                set_reg(1, vals[i]);
                step(enc_i(6'd8, 1, 6, imms[k]), 32'h400, 0);
                mdl[6] = vals[i] + sx(imms[k]);
                step(enc_i(6'd13, 1, 7, imms[k]), 32'h404, 0);
                mdl[7] = vals[i] | {16'h0, imms[k]};
                step(enc_i(6'd10, 1, 8, imms[k]), 32'h408, 0);
                mdl[8] = ($signed(vals[i]) < $signed(sx(imms[k]))) ? 32'd1 : 32'd0;
                cmp_reg("R4 addi", 6);
                cmp_reg("R4 ori", 7);
                cmp_reg("R3 slti", 8);
            end
        end

        // R5: lui clears the low half
        set_reg(9, 32'hFFFF_FFFF);
        step(enc_i(6'd15, 0, 9, 16'hA5C3), 32'h500, 0);
        mdl[9] = 32'hA5C3_0000;
        cmp_reg("R5", 9);

        // R6: writes to register 0 dropped
        set_reg(1, 32'h55);
        step(enc_r(1, 1, 0, 6'd32), 32'h600, 0);
        chk("R6 wb_en", {31'd0, c_wen}, 32'd0);
        cmp_reg("R6 read", 0);
        step(enc_i(6'd8, 0, 0, 16'h7), 32'h604, 0);
        chk("R6 addi wb_en", {31'd0, c_wen}, 32'd0);
        cmp_reg("R6 read", 0);

        // R7: loads
        set_reg(10, 32'h1000);
        step(enc_i(6'd35, 10, 11, 16'hFFFC), 32'h700, 32'hCAFE_F00D);
        chk("R7 lw addr", c_addr, 32'h0FFC);
        chk("R7 lw rd", {31'd0, c_rd}, 32'd1);
        chk("R7 lw be", {28'd0, c_be}, 32'hF);
        mdl[11] = 32'hCAFE_F00D;
        cmp_reg("R7 lw", 11);
        for (int b = 0; b < 4; b++) begin
            logic [7:0] byt;
            step(enc_i(6'd32, 10, 12, 16'(b)), 32'h704, 32'h80_7F_C3_11);
            byt = 8'(32'h807FC311 >> (8 * (3 - b)));
            chk("R7 lb be", {28'd0, c_be}, 32'(4'b1000 >> b));
            mdl[12] = {{24{byt[7]}}, byt};
            cmp_reg("R7 lb", 12);
        end

        // R8: stores
        set_reg(13, 32'h89AB_CDEF);
        step(enc_i(6'd43, 10, 13, 16'h8), 32'h800, 0);
        chk("R8 sw addr", c_addr, 32'h1008);
        chk("R8 sw data", c_wd, 32'h89AB_CDEF);
        chk("R8 sw be", {28'd0, c_be}, 32'hF);
        chk("R8 sw flags", {29'd0, c_wr, c_rd, c_wen}, 32'b100);
        for (int b = 0; b < 4; b++) begin
            step(enc_i(6'd40, 10, 13, 16'(b)), 32'h804, 0);
            chk("R8 sb data", c_wd, 32'hEFEF_EFEF);
            chk("R8 sb be", {28'd0, c_be}, 32'(4'b1000 >> b));
            chk("R8 sb wb", {31'd0, c_wen}, 32'd0);
        end
        cmp_reg("R8 rt kept", 13);

        // R9: branches
        set_reg(1, 32'h42); set_reg(2, 32'h42); set_reg(3, 32'h43);
        step(enc_i(6'd4, 1, 2, 16'hFFFE), 32'h1000, 0);
        chk("R9 beq taken", c_npc, 32'h0FFC);
        step(enc_i(6'd4, 1, 3, 16'hFFFE), 32'h1000, 0);
        chk("R9 beq not", c_npc, 32'h1004);
        step(enc_i(6'd5, 1, 3, 16'h0010), 32'h1000, 0);
        chk("R9 bne taken", c_npc, 32'h1044);
        step(enc_i(6'd5, 1, 2, 16'h0010), 32'h1000, 0);
        chk("R9 bne not", c_npc, 32'h1004);

        // R10: jumps
        step({6'd2, 26'h012_3456}, 32'hA000_0010, 0);
        chk("R10 j", c_npc, {4'hA, 26'h012_3456, 2'b00});
        step({6'd3, 26'h3FF_FFFF}, 32'h5000_0020, 0);
        chk("R10 jal", c_npc, {4'h5, 26'h3FF_FFFF, 2'b00});
        mdl[31] = 32'h5000_0024;
        cmp_reg("R10 link", 31);

        // R11: jr
        set_reg(14, 32'hDEAD_BEE0);
        step(enc_r(14, 0, 0, 6'd8), 32'h1100, 0);
        chk("R11 jr", c_npc, 32'hDEAD_BEE0);

        // R12: illegal words
        set_reg(1, 32'h77);
        step(enc_i(6'd6, 2, 1, 16'h0), 32'h1200, 0);
        chk("R12 flag", {31'd0, c_ill}, 32'd1);
        chk("R12 npc", c_npc, 32'h1204);
        chk("R12 quiet", {29'd0, c_wen, c_rd, c_wr}, 32'd0);
        step(enc_r(2, 2, 1, 6'd0), 32'h1208, 0);
        chk("R12 funct flag", {31'd0, c_ill}, 32'd1);
        cmp_reg("R12 no write", 1);

        // R13: sequential next PC
        step(enc_r(1, 2, 3, 6'd32), 32'hFFFF_FFFC, 0);
        mdl[3] = mdl[1] + mdl[2];
        chk("R13 wrap", c_npc, 32'h0);
        step(enc_i(6'd35, 0, 4, 16'h0), 32'h1300, 0);
        mdl[4] = 32'h0;
        chk("R13 load seq", c_npc, 32'h1304);

        // R1: reset clears again after writes
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        cmp_reg("R1 rereset", 3);
        cmp_reg("R1 rereset", 31);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule